// File: doc/BRIEF.md
# Page-Mode DRAM Burst Sequencer

The sequencer turns one cache-line read request into a four-beat burst on fast-page-mode or extended-data-out DRAM. A requester presents an address while the sequencer shows it is ready. The sequencer decodes the address to one physical rank, decides whether that rank already holds the requested row open, and then drives the row strobes (one per physical rank), the column strobes (one per physical rank), a multiplexed row/column address and a data-valid pulse for each beat.

There are two banks. Each bank has two slots and each slot carries up to two ranks: one for a single-sided module, two for a double-sided one. A per-bank bit chooses which slot is numbered first, so a bank with a single module works in either slot. The usable ranks of a bank are also capped so that the bank never spans more than its address limit. An access past the usable ranks ends with an error pulse and no strobe activity.

Burst timing depends on the memory type, an EDO speed option and an FPM wait-state option. Those patterns hold on a page hit. A page miss first closes and reopens the target row.

Top module: `dram_burst_seq`

## Requirements
- R1: After reset, reqReady is 1, every rasN and casN bit is 1, and dataValid and respErr are 0.
- R2: reqAddr is {bank (MSB), logical rank (2 bits), row (ROW_W), column (COL_W)}. A slot code of 0 means empty, 1 means one rank, and 2 or 3 mean two ranks. Logical ranks take the ranks of the primary slot (cfgPrimSlot[bank]) first, then the ranks of the other slot. The strobe bit for an access is 4*bank + 2*slot + side. The code for bank b, slot s is cfgSlotSides[4b+2s+1:4b+2s].
- R3: A bank's usable rank count is the smaller of its populated ranks and 2^(BANK_LIMIT_LOG-(ROW_W+COL_W+WORD_BYTES_LOG)), and never more than 4. An access to a logical rank at or above that count raises respErr on the clock after acceptance, leaves rasN unchanged and casN all ones, and reqReady is 1 again one clock later.
- R4: A row that has been opened keeps its rank's rasN low until that rank is precharged. An access to the same rank and row is a page hit. Its first dataValid comes L clocks after acceptance and the next three come every B clocks.
- R5: The (L, B) pair is (3,1) for EDO with cfgEdoFast=1, (4,2) for EDO with cfgEdoFast=0, (4,2) for FPM with cfgFpmWait=0 and (5,3) for FPM with cfgFpmWait=1. cfgFpmWait has no effect in EDO mode, and cfgEdoFast has no effect in FPM mode.
- R6: On a page miss, the target rasN is high on clocks 1 and 2 after acceptance and low from clock 3. casN stays high through clock 4, and the hit pattern of R4 then follows, offset by 4 clocks.
- R7: The target's casN bit is low exactly on the clocks where dataValid is 1. All other casN bits stay high, and no casN bit is low while reqReady is 1.
- R8: On precharge and row-open clocks, dramAddr carries the row, zero-extended. On burst clocks it carries the column with its two low bits replaced by (start + beat) mod 4. On each dataValid clock, beatNum gives the beat index 0 to 3.
- R9: reqReady falls on the clock after acceptance and rises on the clock after the fourth dataValid. A request presented while reqReady is 0 is ignored.
- R10: An access never changes the rasN bits of ranks other than its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqAddr | input | COL_W+ROW_W+3 | Request address {bank, rank, row, column} |
| reqReady | output | 1 | Sequencer idle, accepts a request |
| cfgSlotSides | input | 8 | Two-bit population code per bank and slot |
| cfgPrimSlot | input | 2 | Primary slot select per bank |
| cfgEdo | input | 1 | 1 = EDO timing, 0 = FPM timing |
| cfgEdoFast | input | 1 | EDO speed option (3-1-1-1 when 1) |
| cfgFpmWait | input | 1 | FPM added wait state (5-3-3-3 when 1) |
| rasN | output | 8 | Active-low row strobe per physical rank |
| casN | output | 8 | Active-low column strobe per physical rank |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dataValid | output | 1 | Read data beat valid |
| beatNum | output | 2 | Index of the current beat |
| respErr | output | 1 | Access rejected by decode |

## Verification
The hardest situation to reach is an access that decodes correctly only because of the primary-slot swap and the bank-size clamp together. An example is logical rank 1 landing on the secondary slot while a third populated rank is rejected, with other ranks' rows still open from earlier accesses. The bench gets there by sweeping every slot-code pair and both primary settings for each bank. It issues every logical rank twice, so each decoded rank sees a miss and then a hit, and rows opened earlier stay open across configuration changes. It also cycles through all eight timing-option combinations as it goes.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FAULT,
    ST_PRECH,
    ST_OPEN,
    ST_BURST
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;    // latch decoded request
    logic       precharge;  // hold target row strobe inactive
    logic       activate;   // record new open row for target
    logic       casOn;      // assert target column strobe
    logic       selCol;     // drive column onto the address bus
    logic [1:0] beat;       // current beat index
  } seqStrobe_t;

  // ranks contributed by one slot population code
  function automatic logic [2:0] ranksOf(input logic [1:0] code);
    case (code)
      2'd0:    ranksOf = 3'd0;
      2'd1:    ranksOf = 3'd1;
      default: ranksOf = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/dram_seq_datapath.sv
module dram_seq_datapath
  import dram_seq_pkg::*;
#(
  parameter int ROW_W          = 11,
  parameter int COL_W          = 10,
  parameter int WORD_BYTES_LOG = 3,
  parameter int BANK_LIMIT_LOG = 27,
  localparam int ADDR_W        = COL_W + ROW_W + 3,
  localparam int DA_W          = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        cfgSlotSides,
  input  logic [1:0]        cfgPrimSlot,
  input  seqStrobe_t        strb,
  output logic              decodeErr,
  output logic              decodeHit,
  output logic [7:0]        rasN,
  output logic [7:0]        casN,
  output logic [DA_W-1:0]   dramAddr
);

  localparam int NUM_RANKS      = 8;
  localparam int RANK_BYTES_LOG = ROW_W + COL_W + WORD_BYTES_LOG;
  localparam int LIMIT_SHIFT    = BANK_LIMIT_LOG - RANK_BYTES_LOG;
  localparam int MAX_RANKS      = (LIMIT_SHIFT >= 2) ? 4 :
                                  (LIMIT_SHIFT == 1) ? 2 :
                                  (LIMIT_SHIFT == 0) ? 1 : 0;

  // request field split
  logic             bankSel;
  logic [1:0]       logRank;
  logic [ROW_W-1:0] rowIn;
  logic [COL_W-1:0] colIn;

  assign bankSel = reqAddr[ADDR_W-1];
  assign logRank = reqAddr[ADDR_W-2 -: 2];
  assign rowIn   = reqAddr[COL_W +: ROW_W];
  assign colIn   = reqAddr[COL_W-1:0];

  // rank decode with primary-slot ordering and bank clamp
  logic       primSlot;
  logic [2:0] primBase, secBase;
  logic [2:0] primCnt, secCnt, popCnt, usableCnt, restIdx;
  logic       physSlot, physSide;
  logic [2:0] physRank;

  always_comb begin
    primSlot  = cfgPrimSlot[bankSel];
    primBase  = {bankSel, primSlot, 1'b0};
    secBase   = {bankSel, ~primSlot, 1'b0};
    primCnt   = ranksOf(cfgSlotSides[primBase +: 2]);
    secCnt    = ranksOf(cfgSlotSides[secBase +: 2]);
    popCnt    = primCnt + secCnt;
    usableCnt = (popCnt > 3'(MAX_RANKS)) ? 3'(MAX_RANKS) : popCnt;
    decodeErr = ({1'b0, logRank} >= usableCnt);
    restIdx   = {1'b0, logRank} - primCnt;
    if ({1'b0, logRank} < primCnt) begin
      physSlot = primSlot;
      physSide = logRank[0];
    end else begin
      physSlot = ~primSlot;
      physSide = restIdx[0];
    end
    physRank = {bankSel, physSlot, physSide};
  end

  // open-row table, one entry per physical rank
  logic [NUM_RANKS-1:0] openVld;
  logic [ROW_W-1:0]     openRow [NUM_RANKS];

  assign decodeHit = openVld[physRank] && (openRow[physRank] == rowIn);

  // latched target of the running access
  logic [2:0]       tgtRank;
  logic [ROW_W-1:0] tgtRow;
  logic [COL_W-1:0] tgtCol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtRank <= '0;
      tgtRow  <= '0;
      tgtCol  <= '0;
    end else if (strb.capture) begin
      tgtRank <= physRank;
      tgtRow  <= rowIn;
      tgtCol  <= colIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openVld <= '0;
      for (int i = 0; i < NUM_RANKS; i++) openRow[i] <= '0;
    end else if (strb.activate) begin
      openVld[tgtRank] <= 1'b1;
      openRow[tgtRank] <= tgtRow;
    end
  end

  // per-rank strobe generation
  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_strobe
    assign rasN[g] = ~(openVld[g] && !(strb.precharge && (tgtRank == 3'(g))));
    assign casN[g] = ~(strb.casOn && (tgtRank == 3'(g)));
  end

  // address multiplexer with wrapping beat column
  logic [DA_W-1:0] rowExt, colExt;
  logic [1:0]      colLow;

  always_comb begin
    colLow              = tgtCol[1:0] + strb.beat;
    rowExt              = '0;
    rowExt[ROW_W-1:0]   = tgtRow;
    colExt              = '0;
    colExt[COL_W-1:0]   = {tgtCol[COL_W-1:2], colLow};
    dramAddr            = strb.selCol ? colExt : rowExt;
  end

  assert_single_cas_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~casN));

  assert_row_open_on_cas_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.casOn |-> !rasN[tgtRank]);

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int PRE_CLKS = 2,
  parameter int ACT_CLKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       decodeErr,
  input  logic       decodeHit,
  input  logic       cfgEdo,
  input  logic       cfgEdoFast,
  input  logic       cfgFpmWait,
  output logic       reqReady,
  output logic       dataValid,
  output logic       respErr,
  output logic [1:0] beatNum,
  output seqStrobe_t strb
);

  localparam int CNT_W = $clog2(PRE_CLKS + ACT_CLKS + 8);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       beat;
  logic [2:0]       leadSel, burstSel, leadR, burstR;
  logic             accept;

  // page-hit timing pattern: burst window is two clocks shorter than lead-off
  always_comb begin
    if (cfgEdo) leadSel = cfgEdoFast ? 3'd3 : 3'd4;
    else        leadSel = cfgFpmWait ? 3'd5 : 3'd4;
    burstSel = leadSel - 3'd2;
  end

  assign accept = reqValid && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      beat   <= '0;
      leadR  <= 3'd4;
      burstR <= 3'd2;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            leadR  <= leadSel;
            burstR <= burstSel;
            beat   <= '0;
            if (decodeErr) begin
              state <= ST_FAULT;
            end else if (decodeHit) begin
              state <= ST_BURST;
              cnt   <= CNT_W'(leadSel) - CNT_W'(1);
            end else begin
              state <= ST_PRECH;
              cnt   <= CNT_W'(PRE_CLKS - 1);
            end
          end
        end
        ST_FAULT: state <= ST_IDLE;
        ST_PRECH: begin
          if (cnt == '0) begin
            state <= ST_OPEN;
            cnt   <= CNT_W'(ACT_CLKS - 1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_OPEN: begin
          if (cnt == '0) begin
            state <= ST_BURST;
            cnt   <= CNT_W'(leadR) - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_BURST: begin
          if (cnt == '0) begin
            if (beat == 2'd3) begin
              state <= ST_IDLE;
            end else begin
              beat <= beat + 2'd1;
              cnt  <= CNT_W'(burstR) - CNT_W'(1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady       = (state == ST_IDLE);
    respErr        = (state == ST_FAULT);
    dataValid      = (state == ST_BURST) && (cnt == '0);
    beatNum        = beat;
    strb.capture   = accept;
    strb.precharge = (state == ST_PRECH);
    strb.activate  = (state == ST_PRECH) && (cnt == '0);
    strb.casOn     = dataValid;
    strb.selCol    = (state == ST_BURST);
    strb.beat      = beat;
  end

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  assert_fault_short_R3: assert property (@(posedge clk) disable iff (!rstN)
    respErr |=> reqReady);

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W          = 11,
  parameter int COL_W          = 10,
  parameter int WORD_BYTES_LOG = 3,
  parameter int BANK_LIMIT_LOG = 27,
  parameter int PRE_CLKS       = 2,
  parameter int ACT_CLKS       = 2,
  localparam int ADDR_W        = COL_W + ROW_W + 3,
  localparam int DA_W          = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  input  logic [7:0]        cfgSlotSides,
  input  logic [1:0]        cfgPrimSlot,
  input  logic              cfgEdo,
  input  logic              cfgEdoFast,
  input  logic              cfgFpmWait,
  output logic [7:0]        rasN,
  output logic [7:0]        casN,
  output logic [DA_W-1:0]   dramAddr,
  output logic              dataValid,
  output logic [1:0]        beatNum,
  output logic              respErr
);

  seqStrobe_t strb;
  logic       decodeErr;
  logic       decodeHit;

  dram_seq_ctrl #(
    .PRE_CLKS (PRE_CLKS),
    .ACT_CLKS (ACT_CLKS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .decodeErr  (decodeErr),
    .decodeHit  (decodeHit),
    .cfgEdo     (cfgEdo),
    .cfgEdoFast (cfgEdoFast),
    .cfgFpmWait (cfgFpmWait),
    .reqReady   (reqReady),
    .dataValid  (dataValid),
    .respErr    (respErr),
    .beatNum    (beatNum),
    .strb       (strb)
  );

  dram_seq_datapath #(
    .ROW_W          (ROW_W),
    .COL_W          (COL_W),
    .WORD_BYTES_LOG (WORD_BYTES_LOG),
    .BANK_LIMIT_LOG (BANK_LIMIT_LOG)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqAddr      (reqAddr),
    .cfgSlotSides (cfgSlotSides),
    .cfgPrimSlot  (cfgPrimSlot),
    .strb         (strb),
    .decodeErr    (decodeErr),
    .decodeHit    (decodeHit),
    .rasN         (rasN),
    .casN         (casN),
    .dramAddr     (dramAddr)
  );

  assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> ((&casN) && (rasN == $past(rasN))));

  assert_valid_cas_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> ($countones(~casN) == 1));

  assert_idle_no_cas_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (&casN));

  assert_last_beat_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && (beatNum == 2'd3)) |=> reqReady);

endmodule

// File: tb/sim_dram_burst_seq.sv
module sim_dram_burst_seq;

  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int ADDR_W = COL_W + ROW_W + 3;
  localparam int DA_W   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady;
  logic [7:0]        cfgSlotSides = '0;
  logic [1:0]        cfgPrimSlot = '0;
  logic              cfgEdo = 1'b0, cfgEdoFast = 1'b0, cfgFpmWait = 1'b0;
  logic [7:0]        rasN, casN;
  logic [DA_W-1:0]   dramAddr;
  logic              dataValid, respErr;
  logic [1:0]        beatNum;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  bit done   = 0;

  // bench model of open rows
  bit       mVld [8];
  int       mRow [8];

  always #10 clk = ~clk;

  dram_burst_seq #(
    .ROW_W (ROW_W), .COL_W (COL_W), .WORD_BYTES_LOG (3), .BANK_LIMIT_LOG (12)
  ) u0 (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqAddr (reqAddr),
    .reqReady (reqReady), .cfgSlotSides (cfgSlotSides), .cfgPrimSlot (cfgPrimSlot),
    .cfgEdo (cfgEdo), .cfgEdoFast (cfgEdoFast), .cfgFpmWait (cfgFpmWait),
    .rasN (rasN), .casN (casN), .dramAddr (dramAddr), .dataValid (dataValid),
    .beatNum (beatNum), .respErr (respErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ranksOf(input int code);
    return (code == 0) ? 0 : (code == 1) ? 1 : 2;
  endfunction

  function automatic logic [7:0] modelRas();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = ~mVld[i];
    return v;
  endfunction

  // one access, every clock of it compared with arithmetic expectations
  task automatic runAccess(input int bank, input int lr, input int row,
                           input int col, input string tTag);
    int prim, pc, sc, usable, slot, side, phys, lead, brst, off, total, j, bt;
    bit err, hit, dv, rasBit;
    logic [7:0] expRas, mask;
    logic [DA_W-1:0] expAddr;

    prim   = cfgPrimSlot[bank];
    pc     = ranksOf(cfgSlotSides[bank*4 + prim*2 +: 2]);
    sc     = ranksOf(cfgSlotSides[bank*4 + (1-prim)*2 +: 2]);
    usable = (pc + sc > 2) ? 2 : pc + sc;
    err    = (lr >= usable);
    if (lr < pc) begin slot = prim; side = lr; end
    else begin slot = 1 - prim; side = lr - pc; end
    phys   = bank*4 + slot*2 + (side & 1);
    hit    = !err && mVld[phys] && (mRow[phys] == row);
    if (cfgEdo) lead = cfgEdoFast ? 3 : 4;
    else        lead = cfgFpmWait ? 5 : 4;
    brst   = lead - 2;
    off    = hit ? 0 : 4;
    total  = err ? 2 : off + lead + 3*brst + 1;
    mask   = 8'(1 << phys);

    @(negedge clk);
    check(reqReady == 1'b1, "R9", "ready before request", reqReady, 1);
    reqValid = 1'b1;
    reqAddr  = ADDR_W'({bank[0], lr[1:0], row[3:0], col[3:0]});
    expRas   = modelRas();
    @(posedge clk);
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (k == 1 && !err) begin
        reqAddr = ~reqAddr;           // request while busy must be ignored
      end else begin
        reqValid = 1'b0;
      end
      if (err) begin
        if (k == 1) begin
          check(respErr == 1'b1, "R3", "error flag", respErr, 1);
          check(reqReady == 1'b0, "R3", "ready during error", reqReady, 0);
          check(casN == 8'hFF, "R3", "cas on error", casN, 8'hFF);
          check(rasN == expRas, "R3", "ras on error", rasN, expRas);
        end else begin
          check(reqReady == 1'b1, "R3", "ready after error", reqReady, 1);
          check(respErr == 1'b0, "R3", "error flag cleared", respErr, 0);
        end
      end else begin
        j  = k - off;
        dv = (k < total) && (j >= lead) && ((j - lead) % brst == 0);
        check(dataValid == dv, tTag, $sformatf("dataValid clk %0d", k), dataValid, dv);
        check(respErr == 1'b0, "R3", "no error on valid access", respErr, 0);
        check(casN == (dv ? ~mask : 8'hFF), "R2", $sformatf("cas position clk %0d", k),
              casN, dv ? ~mask : 8'hFF);
        check($countones(~casN) == (dv ? 1 : 0), "R7", "cas count", $countones(~casN), dv);
        check(reqReady == (k == total), "R9", $sformatf("ready clk %0d", k),
              reqReady, k == total);
        check((rasN & ~mask) == (expRas & ~mask), "R10", "other ranks ras",
              rasN & ~mask, expRas & ~mask);
        rasBit = (!hit && k <= 2) ? 1'b1 : 1'b0;
        check(rasN[phys] == rasBit, hit ? "R4" : "R6", $sformatf("target ras clk %0d", k),
              rasN[phys], rasBit);
        if (k < total) begin
          if (j <= 0) begin
            expAddr = DA_W'(row);
          end else begin
            bt      = (j <= lead) ? 0 : ((j - lead - 1) / brst) + 1;
            expAddr = DA_W'((col & 12) | ((col + bt) & 3));
          end
          check(dramAddr == expAddr, "R8", $sformatf("address clk %0d", k), dramAddr, expAddr);
          if (dv) begin
            bt = (j - lead) / brst;
            check(beatNum == 2'(bt), "R8", "beat index", beatNum, bt);
          end
        end
      end
    end
    if (!err && !hit) begin
      mVld[phys] = 1'b1;
      mRow[phys] = row;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int mode;
    for (int i = 0; i < 8; i++) begin mVld[i] = 0; mRow[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reset ready", reqReady, 1);
    check(rasN == 8'hFF, "R1", "reset ras", rasN, 8'hFF);
    check(casN == 8'hFF, "R1", "reset cas", casN, 8'hFF);
    check(dataValid == 1'b0, "R1", "reset dataValid", dataValid, 0);
    check(respErr == 1'b0, "R1", "reset error", respErr, 0);

    // R5 all timing option combinations, miss then hit
    cfgSlotSides = 8'b0000_0010;
    cfgPrimSlot  = 2'b00;
    for (int t = 0; t < 8; t++) begin
      cfgEdo = t[2]; cfgEdoFast = t[1]; cfgFpmWait = t[0];
      runAccess(0, 0, t + 1, t * 2, "R5");
      runAccess(0, 0, t + 1, t * 2 + 1, "R5");
    end

    // R2 R3 R4 R6 decode sweep over slot codes and primary slot per bank
    mode = 0;
    for (int b = 0; b < 2; b++) begin
      for (int s0 = 0; s0 < 4; s0++) begin
        for (int s1 = 0; s1 < 4; s1++) begin
          for (int p = 0; p < 2; p++) begin
            cfgSlotSides = 8'hAA;
            cfgSlotSides[b*4 +: 4] = 4'({s1[1:0], s0[1:0]});
            cfgPrimSlot  = 2'b00;
            cfgPrimSlot[b] = p[0];
            cfgEdo = mode[2]; cfgEdoFast = mode[1]; cfgFpmWait = mode[0];
            mode = (mode + 1) % 8;
            for (int lr = 0; lr < 4; lr++) begin
              runAccess(b, lr, (s0 + s1 + p + lr) % 16, lr * 4 + 3, "R6");
              runAccess(b, lr, (s0 + s1 + p + lr) % 16, lr * 4 + 1, "R4");
            end
          end
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule